// File: doc/BRIEF.md
# Concurrent Write-One Completion Monitor

This block drives one 64-bit write into a resistive memory row and senses the cells while the write pulse is still applied. It does not read back after the pulse. The 0-to-1 transition is the hard, error-prone one, so the block follows only the bits that flip from 0 to 1. Every cell in the row has a switched flag, and the block takes the flags of those bits from the array's sense path. It drops write enable as soon as each of those bits has reported a switch. Cells driven to 0, or rewritten with a 1 they already hold, get the same pulse, but nobody watches them.

The host presents the new word, the word read from the row before the write, and a pulse-length limit, and it raises a request. The block then sequences the array. It gives one precharge cycle and then holds write enable for as many cycles as the sensing needs. It returns an acknowledge, and that acknowledge carries an error flag when the limit ran out first. A write in which no bit goes from 0 to 1 still receives a fixed minimum pulse.

Top module: `wone_write_ctrl`

## Requirements
- R1: While reset is high and after it falls, `arr_pre`, `arr_we` and `ack` are low until a request is accepted.
- R2: A request is accepted only in the idle state. From then on, `arr_wdata` equals the accepted `req_data` and holds steady for every cycle in which `arr_we` is high.
- R3: Each accepted write produces exactly one `arr_pre` cycle. That cycle is the one immediately before `arr_we` rises, and `arr_pre` is never high together with `arr_we`.
- R4: The monitored set is `req_data & ~req_old`. If it is non-empty, `arr_we` stays high for k cycles, where k is the first pulse cycle by whose end every monitored bit has shown `arr_sw` high. `ack_err` is then 0.
- R5: A monitored bit counts as switched once its `arr_sw` has been high in any pulse cycle, even if the flag drops later.
- R6: `arr_sw` bits outside the monitored set have no effect on pulse length. This covers bits written 0 and bits written 1 over an old 1.
- R7: With an empty monitored set, the pulse lasts MIN_PULSE cycles (default 4) and `ack_err` is 0.
- R8: The pulse never lasts more than L cycles, where L is `req_limit`, or 1 when `req_limit` is 0. Reaching L without completion ends the write with `ack_err` = 1. Completion in cycle L itself gives `ack_err` = 0.
- R9: `arr_sw` values during idle, precharge or acknowledge cycles have no effect on the next pulse.
- R10: A request raised while a write is in progress is ignored. It does not change `arr_wdata` and produces no extra precharge or acknowledge.
- R11: `ack` is high for exactly one cycle, the cycle right after the last `arr_we` cycle, and `ack_err` is only meaningful with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host write request |
| req_data | input | DW | Word to write |
| req_old | input | DW | Row contents read before the write |
| req_limit | input | 12 | Maximum pulse length in cycles (0 is treated as 1) |
| ack | output | 1 | One-cycle write completion |
| ack_err | output | 1 | Write ended by the limit, valid with ack |
| arr_pre | output | 1 | Sense-path precharge |
| arr_we | output | 1 | Array write enable |
| arr_wdata | output | DW | Data bits driven to the cells |
| arr_sw | input | DW | Per-bit switched flag from the sense path |

## Verification
The bench models the array. It schedules, per bit, the pulse cycle at which `arr_sw` rises, and optionally the cycle at which it falls again. It predicts every pulse length and error flag from the rules above. A flag that falls again inside the pulse catches a design with no memory of switched bits, because such a design would run until the limit. Never-switching bits outside the monitored set, and flags held high through idle and precharge, catch designs that watch the wrong bits or sample outside the pulse: the first hangs until the limit and the second ends early. The bench also covers completion landing exactly on the limit, a zero limit, and an empty mask both with a short limit and without one, which exposes off-by-one counters and wrong priority. A request raised mid-write shows up as corrupted write data or as a second acknowledge.

// File: rtl/wone_pkg.sv
package wone_pkg;

    localparam int unsigned CYC_W = 12;

    typedef logic [CYC_W-1:0] cyc_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRE   = 2'd1,
        ST_PULSE = 2'd2,
        ST_ACK   = 2'd3
    } wr_state_e;

    // End-of-pulse conditions presented to the sequencer
    typedef struct packed {
        logic done;     // all monitored bits switched (or minimum met)
        logic expired;  // pulse limit reached
    } pulse_end_t;

    // A zero limit would never allow a pulse; treat it as one cycle
    function automatic cyc_t clamp_limit(cyc_t lim);
        return (lim == '0) ? cyc_t'(1) : lim;
    endfunction

endpackage

// File: rtl/wone_mask_track.sv
module wone_mask_track #(
    parameter int unsigned DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] new_word,
    input  logic [DW-1:0] old_word,
    input  logic          active,
    input  logic [DW-1:0] sw,
    output logic          clear_now,
    output logic          mask_none
);

    logic [DW-1:0] pend;
    logic [DW-1:0] rise_mask;

    assign rise_mask = new_word & ~old_word;

    // One sticky pending bit per cell: set on load, cleared once seen switched
    for (genvar b = 0; b < DW; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[b] <= 1'b0;
            end else if (load) begin
                pend[b] <= rise_mask[b];
            end else if (active && sw[b]) begin
                pend[b] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_none <= 1'b1;
        end else if (load) begin
            mask_none <= (rise_mask == '0);
        end
    end

    // Completion counts switches reported in the current cycle as well
    assign clear_now = ((pend & ~sw) == '0);

    AST_PEND_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!load && !active) |=> $stable(pend)) else $error("pending changed outside pulse"); // R9

    AST_PEND_NO_REGROW: assert property (@(posedge clk) disable iff (rst)
        !$past(load) |-> ((pend & ~$past(pend)) == '0)) else $error("pending bit reappeared"); // R5

endmodule

// File: rtl/wone_pulse_timer.sv
module wone_pulse_timer
    import wone_pkg::*;
#(
    parameter int unsigned MIN_PULSE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    input  cyc_t limit,
    output logic min_met,
    output logic expired
);

    localparam cyc_t MIN_C = cyc_t'(MIN_PULSE);

    cyc_t cnt;
    cyc_t lim_eff;

    assign lim_eff = clamp_limit(limit);

    // cnt holds the number of the current pulse cycle (1-based)
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= cyc_t'(1);
        end else if (active) begin
            cnt <= cnt + cyc_t'(1);
        end
    end

    assign min_met = (cnt >= MIN_C);
    assign expired = (cnt >= lim_eff);

    AST_CNT_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt <= lim_eff)) else $error("pulse exceeded limit"); // R8

    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt != '0)) else $error("pulse counter not started"); // R8

endmodule

// File: rtl/wone_seq_fsm.sv
module wone_seq_fsm
    import wone_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  pulse_end_t fin,
    output wr_state_e  state,
    output logic       capture
);

    wr_state_e nxt;

    always_comb begin
        nxt     = state;
        capture = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt     = ST_PRE;
                    capture = 1'b1;
                end
            end
            ST_PRE:   nxt = ST_PULSE;
            ST_PULSE: if (fin.done || fin.expired) nxt = ST_ACK;
            ST_ACK:   nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    AST_ACK_FOLLOWS_PULSE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACK) |-> ($past(state) == ST_PULSE)) else $error("ack without pulse"); // R11

    AST_PRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PRE) |=> (state == ST_PULSE)) else $error("precharge not single"); // R3

endmodule

// File: rtl/wone_write_ctrl.sv
module wone_write_ctrl
    import wone_pkg::*;
#(
    parameter int unsigned DW        = 64,
    parameter int unsigned MIN_PULSE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [DW-1:0]    req_data,
    input  logic [DW-1:0]    req_old,
    input  logic [CYC_W-1:0] req_limit,
    output logic             ack,
    output logic             ack_err,
    output logic             arr_pre,
    output logic             arr_we,
    output logic [DW-1:0]    arr_wdata,
    input  logic [DW-1:0]    arr_sw
);

    wr_state_e  state;
    logic       capture;
    pulse_end_t fin;
    logic       active;
    logic       clear_now;
    logic       mask_none;
    logic       min_met;
    logic       expired;
    logic [DW-1:0] data_q;
    cyc_t       limit_q;
    logic       err_q;

    assign active = (state == ST_PULSE);

    wone_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .fin       (fin),
        .state     (state),
        .capture   (capture)
    );

    wone_mask_track #(.DW(DW)) u_track (
        .clk       (clk),
        .rst       (rst),
        .load      (capture),
        .new_word  (req_data),
        .old_word  (req_old),
        .active    (active),
        .sw        (arr_sw),
        .clear_now (clear_now),
        .mask_none (mask_none)
    );

    wone_pulse_timer #(.MIN_PULSE(MIN_PULSE)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (state == ST_PRE),
        .active  (active),
        .limit   (limit_q),
        .min_met (min_met),
        .expired (expired)
    );

    // Completion wins over the limit when both land in the same cycle
    always_comb begin
        fin.done    = active && (mask_none ? min_met : clear_now);
        fin.expired = active && expired;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            limit_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (capture) begin
                data_q  <= req_data;
                limit_q <= cyc_t'(req_limit);
            end
            if (fin.done || fin.expired) begin
                err_q <= !fin.done;
            end
        end
    end

    assign arr_pre   = (state == ST_PRE);
    assign arr_we    = active;
    assign arr_wdata = data_q;
    assign ack       = (state == ST_ACK);
    assign ack_err   = ack && err_q;

    AST_PRE_BEFORE_WE: assert property (@(posedge clk) disable iff (rst)
        $rose(arr_we) |-> $past(arr_pre)) else $error("write without precharge"); // R3

    AST_PRE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(arr_pre && arr_we)) else $error("precharge during write"); // R3

    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (arr_we && $past(arr_we)) |-> $stable(arr_wdata)) else $error("write data moved"); // R2

    AST_ACK_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(arr_we) |-> ack) else $error("no ack after pulse"); // R11

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack) else $error("ack too long"); // R11

endmodule

// File: tb/sim_wone_write_ctrl.sv
module sim_wone_write_ctrl;
    import wone_pkg::*;

    localparam int DW   = 64;
    localparam int MINP = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic             req_valid = 1'b0;
    logic [DW-1:0]    req_data  = '0;
    logic [DW-1:0]    req_old   = '0;
    logic [CYC_W-1:0] req_limit = '0;
    logic             ack, ack_err, arr_pre, arr_we;
    logic [DW-1:0]    arr_wdata;
    logic [DW-1:0]    arr_sw = '0;

    wone_write_ctrl #(.DW(DW), .MIN_PULSE(MINP)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_data(req_data),
        .req_old(req_old), .req_limit(req_limit), .ack(ack), .ack_err(ack_err),
        .arr_pre(arr_pre), .arr_we(arr_we), .arr_wdata(arr_wdata), .arr_sw(arr_sw)
    );

    typedef struct {
        int          len;
        bit          err;
        logic [63:0] data;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          fails  = 0;
    int          sw_at[DW];   // pulse cycle where flag rises, 0 = never
    int          sw_end[DW];  // last pulse cycle flag stays high, 0 = forever
    logic [DW-1:0] idle_sw = '0;
    int          cur_len = 0;
    int          pre_cnt = 0;
    int          pre_total = 0;
    int          acks = 0;
    bit          pre_prev = 1'b0;
    bit          ack_prev = 1'b0;

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic sw_all(int at);
        for (int i = 0; i < DW; i++) begin
            sw_at[i]  = at;
            sw_end[i] = 0;
        end
    endtask

    // Monitor: array model plus scoreboard comparison
    always @(negedge clk) begin
        if (!rst) begin
            if (arr_we) begin
                if (cur_len == 0) check(pre_prev, "R3", "precharge before pulse", 0, 1);
                check(!arr_pre, "R3", "precharge during pulse", 1, 0);
                cur_len++;
                if (sb.size() > 0)
                    check(arr_wdata == sb[0].data, "R2", "write data", arr_wdata, sb[0].data);
                for (int i = 0; i < DW; i++)
                    arr_sw[i] = (sw_at[i] != 0) && (cur_len >= sw_at[i]) &&
                                ((sw_end[i] == 0) || (cur_len <= sw_end[i]));
            end else begin
                arr_sw = idle_sw;
            end
            if (ack) begin
                check(!ack_prev, "R11", "ack width", 2, 1);
                check(!arr_we, "R11", "ack with write enable", 1, 0);
                if (sb.size() == 0) begin
                    check(1'b0, "R10", "unexpected ack", 1, 0);
                end else begin
                    check(cur_len == sb[0].len, sb[0].tag, "pulse length", cur_len, sb[0].len);
                    check(ack_err == sb[0].err, sb[0].tag, "error flag", ack_err, sb[0].err);
                    check(pre_cnt == 1, "R3", "precharges per write", pre_cnt, 1);
                    void'(sb.pop_front());
                end
                acks++;
                cur_len = 0;
                pre_cnt = 0;
            end
            if (arr_pre) begin
                pre_cnt++;
                pre_total++;
            end
            pre_prev = arr_pre;
            ack_prev = ack;
        end
    end

    // Driver: compute the expected outcome, push it, issue the request
    task automatic do_write(logic [DW-1:0] d, logic [DW-1:0] o, int lim, string tag);
        exp_t e;
        logic [DW-1:0] m;
        int lc, s, tgt;
        m  = d & ~o;
        lc = (lim == 0) ? 1 : lim;
        if (m == '0) begin
            e.len = (MINP < lc) ? MINP : lc;
            e.err = (lc < MINP);
        end else begin
            s = 0;
            for (int i = 0; i < DW; i++)
                if (m[i]) s = (sw_at[i] == 0 || s == 1000000) ? 1000000 : ((sw_at[i] > s) ? sw_at[i] : s);
            e.len = (s < lc) ? s : lc;
            e.err = (s > lc);
        end
        e.data = d;
        e.tag  = tag;
        sb.push_back(e);
        tgt = acks + 1;
        @(negedge clk);
        req_valid = 1'b1; req_data = d; req_old = o; req_limit = CYC_W'(lim);
        @(negedge clk);
        req_valid = 1'b0;
        wait (acks == tgt);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        sw_all(0);
        repeat (3) @(negedge clk);
        check(!arr_pre && !arr_we && !ack, "R1", "outputs in reset", {arr_pre, arr_we, ack}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!arr_pre && !arr_we && !ack, "R1", "outputs after reset", {arr_pre, arr_we, ack}, 0);

        // R4: all rising bits switch at cycle 3
        sw_all(3);
        do_write(64'h00FF_00FF_1234_5678, 64'h0, 20, "R4");

        // R4: staggered switching, latest bit at cycle 9
        sw_all(2); sw_at[40] = 9; sw_at[7] = 5;
        do_write(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 30, "R4");

        // R5: bit 5 flag high only in cycle 2, others rise at 6
        sw_all(6); sw_at[5] = 2; sw_end[5] = 2;
        do_write(64'h0000_0000_0000_00F0 | 64'h20, 64'h0, 40, "R5");

        // R6: only bit 3 rises (0->1); bits written 0 and 1-over-1 never switch
        sw_all(0); sw_at[3] = 2;
        do_write(64'hF000_0000_0000_0008, 64'hF000_0000_0000_0F00, 25, "R6");

        // R7: empty monitored set
        sw_all(0);
        do_write(64'h1111_2222_3333_4444, 64'h1111_2222_3333_4444, 30, "R7");
        do_write(64'h0, 64'hFFFF_0000_FFFF_0000, 30, "R7");

        // R8: timeout, completion on limit, zero limit, empty mask with short limit
        sw_all(0);
        do_write(64'h0000_0000_0000_0001, 64'h0, 7, "R8");
        sw_all(7);
        do_write(64'h0000_0000_0000_0001, 64'h0, 7, "R8");
        sw_all(5);
        do_write(64'h0000_0000_0000_0001, 64'h0, 0, "R8");
        sw_all(0);
        do_write(64'h5, 64'h5, 2, "R8");

        // R9: flags held high outside the pulse, never inside it
        sw_all(0); idle_sw = '1;
        do_write(64'h0000_0000_0000_0F00, 64'h0, 6, "R9");
        sw_all(2);
        do_write(64'h0000_0000_0000_0F00, 64'h0, 6, "R9");
        idle_sw = '0;

        // R10: request raised mid-write is ignored
        sw_all(12);
        fork
            do_write(64'hA5A5_A5A5_A5A5_A5A5, 64'h0, 50, "R10");
            begin
                wait (arr_we);
                repeat (3) @(negedge clk);
                req_valid = 1'b1; req_data = 64'h0123_4567_89AB_CDEF; req_old = '0;
                repeat (2) @(negedge clk);
                req_valid = 1'b0;
            end
        join
        repeat (6) @(negedge clk);
        check(acks == 13, "R10", "ack count", acks, 13);
        check(pre_total == 13, "R10", "precharge count", pre_total, 13);
        check(!arr_we && !arr_pre, "R10", "idle after write", {arr_we, arr_pre}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule